// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Burst Controller

This block turns word and cache-line requests from an internal port into strobe-driven DRAM cycles on a multiplexed address bus. A line request moves 32 bytes. With a 64-bit data bus, that is four data beats. A single-word request moves one beat. The beat order is critical-word-first: the first beat carries the word that was asked for. The next beats step through the rest of the 32-byte-aligned line and wrap at the line boundary. This order applies to reads (line fills) and to writes (write-backs).

A configuration bit is sampled when a request is accepted, and it picks one of two modes. In fast page mode, the row phase is issued once and then only the column address changes for each beat. In normal mode, every beat gets its own row phase, column phase and precharge. The controller takes one request at a time. It signals completion with a one-cycle pulse after the final precharge.

Top module: `fpm_burst_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the strobes are inactive (ras_n=1, cas_n=1), done=0, mem_dq_oe=0 and req_ready=1.
- R2: A line request (req_line=1) with cfg_burst_en=1 gives exactly one ras_n falling edge and four column beats. It completes in 11 cycles: done is high at the 11th rising edge after the accepting edge.
- R3: A line request with cfg_burst_en=0 gives four ras_n falling edges, one per beat. It completes in 20 cycles.
- R4: req_addr is a word address. Its top ROW_W bits are the row and its low COL_W bits are the column. Each row phase drives the row on mem_addr. Beat k drives a column whose upper bits equal the requested column and whose low 2 bits are (start+k) mod 4, where start is req_addr[1:0].
- R5: For reads, the data sampled in the beat whose column low bits are i ends up in rdata[64*i +: 64].
- R6: For writes, we_n is low for the whole access and mem_dq_oe is high during the column phases. The beat whose column low bits are i drives req_wdata[64*i +: 64]. For reads, we_n stays high and mem_dq_oe stays low.
- R7: A single-word request (req_line=0) runs one beat at the requested column and completes in 5 cycles, in either mode.
- R8: done is a one-cycle pulse. req_ready is low from the accepting edge until the cycle done is high. A request held on req_valid while the controller is busy is not accepted.
- R9: cas_n is low only while ras_n is low. ras_n is high for two cycles per row phase (setup plus precharge): two cycles per access in fast page mode, and eight in normal mode for a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_en | input | 1 | 1 = fast page mode, 0 = normal mode; sampled at accept |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | 1 | 1 = 32-byte line, 0 = one bus word |
| req_addr | input | ROW_W+COL_W (20) | Word address: row above column |
| req_wdata | input | 256 | Write line, word i in bits 64*i +: 64 |
| req_ready | output | 1 | Idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 256 | Read line, word i in bits 64*i +: 64 |
| mem_addr | output | max(ROW_W,COL_W) (10) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Low for write accesses |
| mem_dq_o | output | 64 | Write data to memory |
| mem_dq_oe | output | 1 | Write data drive enable |
| mem_dq_i | input | 64 | Read data from memory |

## Verification
Line reads and writes are run with start words 0 through 3. Start 0 shows the plain ascending order, and start 3 makes the column index wrap at once. Each of these patterns is run in both modes. The two modes differ only in the number of row phases and total cycles, so comparing them confirms that the mode bit changes timing and not the data or the order. Single-word requests separate the line path from the one-beat path. A request held on req_valid while the controller is busy shows whether the busy guard holds. Random mixes of all of these vary the row, the column and the data.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int LINE_BYTES = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW1,
        ST_ROW2,
        ST_COL1,
        ST_COL2,
        ST_PRE
    } fpm_state_e;

    typedef struct packed {
        logic write;
        logic line;
        logic fast;
    } fpm_mode_t;

    function automatic logic row_active(fpm_state_e s);
        return (s == ST_ROW2) || (s == ST_COL1) || (s == ST_COL2);
    endfunction

    function automatic logic col_phase(fpm_state_e s);
        return (s == ST_COL1) || (s == ST_COL2);
    endfunction

    function automatic logic row_phase(fpm_state_e s);
        return (s == ST_ROW1) || (s == ST_ROW2);
    endfunction

endpackage

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int BEATS = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  fpm_mode_t        start_mode,
    output fpm_state_e       state,
    output logic [IDX_W-1:0] beat,
    output fpm_mode_t        mode,
    output logic             done
);

    logic last_beat;

    assign last_beat = !mode.line || (beat == IDX_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= '0;
            mode  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_ROW1;
                        beat  <= '0;
                        mode  <= start_mode;
                    end
                end
                ST_ROW1: state <= ST_ROW2;
                ST_ROW2: state <= ST_COL1;
                ST_COL1: state <= ST_COL2;
                ST_COL2: begin
                    if (!last_beat && mode.fast) begin
                        state <= ST_COL1;
                        beat  <= beat + 1'b1;
                    end else begin
                        state <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (last_beat) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_ROW1;
                        beat  <= beat + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fpm_addr_gen.sv
module fpm_addr_gen
    import fpm_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int COL_W = 10,
    parameter int IDX_W = 2,
    parameter int MA_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    input  logic [IDX_W-1:0] beat,
    input  fpm_state_e       state,
    output logic [MA_W-1:0]  mem_addr,
    output logic [IDX_W-1:0] slot
);

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] col_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            row_q <= row_in;
            col_q <= col_in;
        end
    end

    // wrap inside the line: low index bits roll over naturally
    assign slot    = col_q[IDX_W-1:0] + beat;
    assign col_cur = {col_q[COL_W-1:IDX_W], slot};

    always_comb begin
        mem_addr = '0;
        if (row_phase(state))
            mem_addr = MA_W'(row_q);
        else if (col_phase(state))
            mem_addr = MA_W'(col_cur);
    end

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
    import fpm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    parameter int IDX_W  = 2,
    localparam int LINE_W = DATA_W * BEATS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              is_write,
    input  fpm_state_e        state,
    input  logic [IDX_W-1:0]  slot,
    input  logic [LINE_W-1:0] wline,
    input  logic [DATA_W-1:0] dq_i,
    output logic [LINE_W-1:0] rline,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    logic [LINE_W-1:0] wline_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wline_q <= '0;
            rline   <= '0;
        end else begin
            if (load)
                wline_q <= wline;
            if (state == ST_COL2 && !is_write)
                rline[slot*DATA_W +: DATA_W] <= dq_i;
        end
    end

    assign dq_o  = wline_q[slot*DATA_W +: DATA_W];
    assign dq_oe = is_write && col_phase(state);

endmodule

// File: rtl/fpm_burst_ctrl.sv
module fpm_burst_ctrl
    import fpm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    localparam int BUS_BYTES = DATA_W / 8,
    localparam int BEATS  = LINE_BYTES / BUS_BYTES,
    localparam int IDX_W  = $clog2(BEATS),
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int LINE_W = DATA_W * BEATS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_burst_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_line,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [LINE_W-1:0] rdata,
    output logic [MA_W-1:0]   mem_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    fpm_state_e       state;
    fpm_mode_t        mode;
    fpm_mode_t        start_mode;
    logic [IDX_W-1:0] beat;
    logic [IDX_W-1:0] slot;
    logic             accept;

    assign accept     = req_valid && (state == ST_IDLE);
    assign start_mode = '{write: req_write, line: req_line, fast: cfg_burst_en};

    fpm_seq #(.BEATS(BEATS), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_mode (start_mode),
        .state      (state),
        .beat       (beat),
        .mode       (mode),
        .done       (done)
    );

    fpm_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .IDX_W(IDX_W), .MA_W(MA_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .row_in   (req_addr[ADDR_W-1:COL_W]),
        .col_in   (req_addr[COL_W-1:0]),
        .beat     (beat),
        .state    (state),
        .mem_addr (mem_addr),
        .slot     (slot)
    );

    fpm_datapath #(.DATA_W(DATA_W), .BEATS(BEATS), .IDX_W(IDX_W)) u_data (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .is_write (mode.write),
        .state    (state),
        .slot     (slot),
        .wline    (req_wdata),
        .dq_i     (mem_dq_i),
        .rline    (rdata),
        .dq_o     (mem_dq_o),
        .dq_oe    (mem_dq_oe)
    );

    assign req_ready = (state == ST_IDLE);
    assign ras_n     = !row_active(state);
    assign cas_n     = (state != ST_COL2);
    assign we_n      = !(mode.write && (state != ST_IDLE));

endmodule

// File: rtl/fpm_burst_ctrl_chk.sv
module fpm_burst_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic mem_dq_oe
);

    p_rst_idle_r1: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && req_ready && !done && !mem_dq_oe));

    p_cas_in_row_r9: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    p_precharge_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |=> ras_n);

    p_oe_write_r6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!we_n && !ras_n));

    p_cas_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        !cas_n |=> cas_n);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind fpm_burst_ctrl fpm_burst_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/fpm_burst_ctrl_bench.sv
module fpm_burst_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_burst_en;
    logic         req_valid;
    logic         req_write;
    logic         req_line;
    logic [19:0]  req_addr;
    logic [255:0] req_wdata;
    logic         req_ready;
    logic         done;
    logic [255:0] rdata;
    logic [9:0]   mem_addr;
    logic         ras_n;
    logic         cas_n;
    logic         we_n;
    logic [63:0]  mem_dq_o;
    logic         mem_dq_oe;
    logic [63:0]  mem_dq_i;

    int checks = 0;
    int fails  = 0;

    // memory model state
    logic        active = 1'b0;
    logic        prev_ras = 1'b1;
    logic [9:0]  row_lat = '0;
    int          falls, ras_hi, nb;
    logic [9:0]  clog [8];
    logic [63:0] wlog [8];
    logic        wen  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_burst_ctrl u_fpm_burst_ctrl (
        .clk(clk), .rst(rst), .cfg_burst_en(cfg_burst_en),
        .req_valid(req_valid), .req_write(req_write), .req_line(req_line),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .mem_addr(mem_addr), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic logic [63:0] pat(logic [9:0] r, logic [9:0] c);
        return {r, c, 12'hABC, ~r, ~c, 12'h5E1};
    endfunction

    assign mem_dq_i = pat(row_lat, mem_addr);

    always @(negedge clk) begin
        if (active) begin
            if (prev_ras && !ras_n) begin
                falls++;
                row_lat = mem_addr;
            end
            if (ras_n) ras_hi++;
            if (!cas_n && nb < 8) begin
                clog[nb] = mem_addr;
                wlog[nb] = mem_dq_o;
                wen[nb]  = !we_n && mem_dq_oe;
                nb++;
            end
            prev_ras = ras_n;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic wr, input logic ln, input logic fb,
                       input logic [19:0] a, input logic [255:0] wd,
                       input logic hold);
        int cyc, busy_bad, nbeats, exp_cyc, exp_falls, exp_hi;
        logic [1:0] s;
        logic [9:0] col;
        @(negedge clk);
        req_write = wr; req_line = ln; cfg_burst_en = fb;
        req_addr = a; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk); #1;
        falls = 0; ras_hi = 0; nb = 0; prev_ras = 1'b1; active = 1'b1;
        if (!hold) req_valid = 1'b0;
        else req_addr = a ^ 20'h00404;
        cyc = 0; busy_bad = 0;
        while (!done && cyc < 64) begin
            @(posedge clk); #1;
            cyc++;
            if (!done && req_ready) busy_bad++;
        end
        active = 1'b0;
        req_valid = 1'b0;
        nbeats    = ln ? 4 : 1;
        exp_cyc   = !ln ? 5 : (fb ? 11 : 20);
        exp_falls = (ln && !fb) ? 4 : 1;
        exp_hi    = 2 * exp_falls;
        if (!ln)       chk("R7 cycles", 64'(cyc), 64'(exp_cyc));
        else if (fb)   chk("R2 cycles", 64'(cyc), 64'(exp_cyc));
        else           chk("R3 cycles", 64'(cyc), 64'(exp_cyc));
        chk(fb ? "R2 row phases" : "R3 row phases", 64'(falls), 64'(exp_falls));
        chk("R9 ras high cycles", 64'(ras_hi), 64'(exp_hi));
        chk("R7 beat count", 64'(nb), 64'(nbeats));
        chk("R4 row", 64'(row_lat), 64'(a[19:10]));
        chk("R8 busy ready", 64'(busy_bad), 64'd0);
        for (int k = 0; k < nbeats; k++) begin
            s   = a[1:0] + 2'(k);
            col = {a[9:2], s};
            chk("R4 column order", 64'(clog[k]), 64'(col));
            chk("R6 write enable", 64'(wen[k]), 64'(wr));
            if (wr)
                chk("R6 write data", wlog[k], wd[s*64 +: 64]);
            else
                chk("R5 read data", rdata[s*64 +: 64], pat(a[19:10], col));
        end
        @(posedge clk); #1;
        chk("R8 done pulse", 64'(done), 64'd0);
        chk("R8 no held accept", 64'(req_ready), 64'd1);
        chk("R1 idle strobes", 64'({ras_n, cas_n, we_n, mem_dq_oe}), 64'b1110);
    endtask

    function automatic logic [255:0] rline();
        return {$urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1; cfg_burst_en = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_line = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset outputs", 64'({ras_n, cas_n, done, mem_dq_oe, req_ready}), 64'b11001);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 after reset", 64'({ras_n, cas_n, done, mem_dq_oe, req_ready}), 64'b11001);

        run(1'b0, 1'b1, 1'b1, 20'h2A5_00, '0, 1'b0);       // burst read, start 0
        run(1'b0, 1'b1, 1'b1, 20'h13F_3B, '0, 1'b0);       // burst read, start 3 wraps
        run(1'b0, 1'b1, 1'b0, 20'h0C3_42, '0, 1'b0);       // normal read, start 2
        run(1'b1, 1'b1, 1'b1, 20'h3FF_05, rline(), 1'b0);  // burst write, start 1
        run(1'b1, 1'b1, 1'b0, 20'h001_FF, rline(), 1'b0);  // normal write, start 3
        run(1'b0, 1'b0, 1'b1, 20'h155_2E, '0, 1'b0);       // single read
        run(1'b1, 1'b0, 1'b0, 20'h0AA_11, rline(), 1'b0);  // single write
        run(1'b0, 1'b1, 1'b1, 20'h222_81, '0, 1'b1);       // request held while busy

        for (int i = 0; i < 40; i++) begin
            run(1'($urandom), 1'($urandom), 1'($urandom), 20'($urandom), rline(), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule